// File: doc/BRIEF.md
# Dual-Mode Serial Display Write Port

This block receives a write-only serial stream for a display controller and turns it into whole bytes, each tagged as pixel data or as a command. The serial clock, serial data, active-low chip select and data/command pin are asynchronous to the system clock. Each of them passes through a synchronizer, and the rising edges of the serial clock are found in the system clock domain.

A static mode pin selects one of two framings. In 4-wire mode every frame is eight bits, most significant first. The data/command pin is read at the same serial edge that carries the last bit. In 3-wire mode every frame is nine bits. The first bit is the tag (1 means display data, 0 means command), the byte follows most significant bit first, and the data/command pin has no effect.

A finished frame is delivered as a single-cycle `byte_valid` pulse together with the byte and its tag. The downstream side has no ready signal and cannot apply back-pressure, because the serial source cannot be stalled. The consumer must take the byte in the cycle `byte_valid` is high. The byte and tag keep their values until the next pulse.

Top module: `disp_ser_wr_port`

## Requirements
- R1: While `rst_n` is low, `byte_valid` is 0 and `byte_data` and `byte_is_data` are 0.
- R2: In 4-wire mode (`mode_3w`=0), eight rising serial clock edges with chip select low form one byte. The first bit received is bit 7 of `byte_data`.
- R3: In 4-wire mode, `byte_is_data` equals the level of `dc_sel` at the eighth rising edge. Levels of `dc_sel` at the earlier edges of the frame have no effect.
- R4: In 3-wire mode (`mode_3w`=1), a frame is nine rising edges. The first bit is the tag (1 = data, 0 = command), and the next eight bits are bits 7 down to 0 of `byte_data`.
- R5: In 3-wire mode the level of `dc_sel` has no effect on the tag.
- R6: Serial clock edges that arrive while `cs_n` is high produce no byte, and no bits from them appear in a later byte.
- R7: `cs_n` going high in the middle of a frame discards the bits received so far. The next frame after chip select returns low is assembled from its own bits only.
- R8: Each completed frame raises `byte_valid` for exactly one system clock cycle. Back-to-back frames within one chip-select window each give their own pulse.
- R9: Asserting `rst_n` low in the middle of a frame discards the partial frame.
- R10: `byte_data` and `byte_is_data` hold their values in every cycle in which `byte_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | Framing select: 0 = 8-bit frame with data/command pin, 1 = 9-bit frame with leading tag bit |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sck | input | 1 | Serial clock, asynchronous, bits taken on its rising edge |
| sdi | input | 1 | Serial data, asynchronous |
| dc_sel | input | 1 | Data/command pin (1 = data), used in 4-wire mode only |
| byte_valid | output | 1 | Single-cycle pulse for each completed frame |
| byte_data | output | 8 | Received byte |
| byte_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The bench builds the port with `SYNC_STAGES` = 3 instead of the default 2. This shows that a deeper synchronizer changes only the latency of a byte and never its framing. One serial bit spans eight system clocks, so each serial clock phase is wider than the synchronizer delay. This lets the tests move `dc_sel` between bits of a frame, drop chip select after a few bits, and apply reset in the middle of a frame.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] value;
  } ser_word_t;
endpackage

// File: rtl/disp_ser_sync.sv
module disp_ser_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= din;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/disp_ser_edge.sv
module disp_ser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/disp_ser_framer.sv
module disp_ser_framer
  import disp_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_3w,
  input  logic             cs_act,
  input  logic             bit_rise,
  input  logic             bit_val,
  input  logic             dc_lvl,
  output logic             word_valid,
  output ser_word_t        word,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_4W = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_3W = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = mode_3w ? LAST_3W : LAST_4W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!cs_act) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (bit_rise) begin
        if (bit_cnt >= last_idx) begin
          word_valid    <= 1'b1;
          word.value    <= {shreg[BYTE_W-2:0], bit_val};
          word.is_data  <= mode_3w ? shreg[BYTE_W-1] : dc_lvl;
          shreg         <= '0;
          bit_cnt       <= '0;
        end else begin
          shreg   <= {shreg[BYTE_W-2:0], bit_val};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/disp_ser_wr_port.sv
module disp_ser_wr_port
  import disp_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_3w,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dc_sel,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_data
);
  localparam int          N_SYNC   = 4;
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b1000;

  logic [N_SYNC-1:0] raw_pins, syn_pins;
  logic              sck_rise;
  logic [CNT_W-1:0]  bit_cnt;
  ser_word_t         word;

  assign raw_pins = {cs_n, sck, sdi, dc_sel};

  disp_ser_sync #(
    .WIDTH  (N_SYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_pins),
    .dout (syn_pins)
  );

  disp_ser_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (syn_pins[2]),
    .rise (sck_rise)
  );

  disp_ser_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_3w   (mode_3w),
    .cs_act    (~syn_pins[3]),
    .bit_rise  (sck_rise),
    .bit_val   (syn_pins[1]),
    .dc_lvl    (syn_pins[0]),
    .word_valid(byte_valid),
    .word      (word),
    .bit_cnt   (bit_cnt)
  );

  assign byte_data    = word.value;
  assign byte_is_data = word.is_data;
endmodule

// File: rtl/disp_ser_wr_chk.sv
module disp_ser_wr_chk
  import disp_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              byte_is_data,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam int HI_W = 8;
  logic [HI_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_run <= '0;
    else if (!cs_n)         hi_run <= '0;
    else if (hi_run != '1)  hi_run <= hi_run + 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (!byte_valid && byte_data == '0 && !byte_is_data);
    end
  end

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  p_idle_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hi_run) > SYNC_STAGES + 1) |-> !byte_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> ($stable(byte_data) && $stable(byte_is_data)));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= BYTE_W);
endmodule

bind disp_ser_wr_port disp_ser_wr_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .byte_valid  (byte_valid),
  .byte_data   (byte_data),
  .byte_is_data(byte_is_data),
  .bit_cnt     (bit_cnt)
);

// File: tb/test_disp_ser_wr_port.sv
`timescale 1ns/1ps
module test_disp_ser_wr_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_3w = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       dc_sel = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_is_data;

  int checks = 0;
  int failures = 0;
  int n_strobe = 0;
  int n_double = 0;
  logic prev_v = 1'b0;
  logic [7:0] cap_byte [0:63];
  logic       cap_flag [0:63];

  always #5 clk = ~clk;

  disp_ser_wr_port #(.SYNC_STAGES(3)) i_disp_ser_wr_port (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .cs_n(cs_n), .sck(sck),
    .sdi(sdi), .dc_sel(dc_sel), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_is_data(byte_is_data)
  );

  always @(negedge clk) begin
    if (byte_valid) begin
      if (n_strobe < 64) begin
        cap_byte[n_strobe] = byte_data;
        cap_flag[n_strobe] = byte_is_data;
      end
      n_strobe++;
      if (prev_v) n_double++;
    end
    prev_v = byte_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic shift_bit(input logic b);
    sdi = b;
    tick(4);
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
  endtask

  task automatic send_word(input int nbits, input logic [8:0] w);
    for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i]);
    tick(10);
  endtask

  task automatic expect_one(input string req, input int s0, input logic [7:0] b, input logic f);
    chk({req, " strobe count"}, n_strobe, s0 + 1);
    chk({req, " byte"}, cap_byte[s0], b);
    chk({req, " flag"}, cap_flag[s0], f);
  endtask

  task automatic t_reset_r1;
    tick(3);
    chk("R1 valid", byte_valid, 0);
    chk("R1 byte", byte_data, 0);
    chk("R1 flag", byte_is_data, 0);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic t_4w_r2;
    int s0;
    mode_3w = 1'b0; cs_n = 1'b0; tick(6);
    s0 = n_strobe; dc_sel = 1'b1; send_word(8, 9'h0A5);
    expect_one("R2 A5 data", s0, 8'hA5, 1'b1);
    s0 = n_strobe; dc_sel = 1'b0; send_word(8, 9'h03C);
    expect_one("R2 3C cmd", s0, 8'h3C, 1'b0);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic t_dc_late_r3;
    int s0;
    logic [7:0] v;
    cs_n = 1'b0; tick(6);
    v = 8'h96; s0 = n_strobe;
    for (int i = 7; i >= 0; i--) begin
      dc_sel = (i == 0);
      shift_bit(v[i]);
    end
    tick(10);
    expect_one("R3 dc high at last edge", s0, 8'h96, 1'b1);
    v = 8'h69; s0 = n_strobe;
    for (int i = 7; i >= 0; i--) begin
      dc_sel = (i != 0);
      shift_bit(v[i]);
    end
    tick(10);
    expect_one("R3 dc low at last edge", s0, 8'h69, 1'b0);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic t_3w_r4_r5;
    int s0;
    mode_3w = 1'b1; cs_n = 1'b0; tick(6);
    s0 = n_strobe; dc_sel = 1'b0; send_word(9, {1'b1, 8'h5A});
    expect_one("R4 tag1 data", s0, 8'h5A, 1'b1);
    s0 = n_strobe; send_word(9, {1'b0, 8'hC3});
    expect_one("R4 tag0 cmd", s0, 8'hC3, 1'b0);
    s0 = n_strobe; dc_sel = 1'b1; send_word(9, {1'b0, 8'h7E});
    expect_one("R5 pin high ignored", s0, 8'h7E, 1'b0);
    s0 = n_strobe; dc_sel = 1'b0; send_word(9, {1'b1, 8'h01});
    expect_one("R5 pin low ignored", s0, 8'h01, 1'b1);
    cs_n = 1'b1; mode_3w = 1'b0; tick(8);
  endtask

  task automatic t_idle_r6;
    int s0;
    s0 = n_strobe;
    for (int i = 0; i < 20; i++) shift_bit(i[0]);
    tick(10);
    chk("R6 no strobe while deselected", n_strobe, s0);
    cs_n = 1'b0; tick(6);
    s0 = n_strobe; dc_sel = 1'b1; send_word(8, 9'h0E7);
    expect_one("R6 no stale bits", s0, 8'hE7, 1'b1);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic t_abort_r7;
    int s0;
    cs_n = 1'b0; tick(6);
    s0 = n_strobe;
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    cs_n = 1'b1; tick(10);
    chk("R7 no strobe from partial", n_strobe, s0);
    cs_n = 1'b0; tick(6);
    dc_sel = 1'b0; send_word(8, 9'h081);
    expect_one("R7 clean frame", s0, 8'h81, 1'b0);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic t_b2b_r8;
    int s0;
    cs_n = 1'b0; tick(6);
    s0 = n_strobe; dc_sel = 1'b1;
    for (int i = 7; i >= 0; i--) shift_bit(8'h12 >> i);
    for (int i = 7; i >= 0; i--) shift_bit(8'h34 >> i);
    tick(10);
    chk("R8 two strobes", n_strobe, s0 + 2);
    chk("R8 first byte", cap_byte[s0], 8'h12);
    chk("R8 second byte", cap_byte[s0+1], 8'h34);
    chk("R8 single-cycle pulses", n_double, 0);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic t_hold_r10;
    tick(30);
    chk("R10 byte held", byte_data, 8'h34);
    chk("R10 flag held", byte_is_data, 1);
  endtask

  task automatic t_reset_mid_r9;
    int s0;
    cs_n = 1'b0; tick(6);
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    rst_n = 1'b0; tick(3);
    chk("R9 R1 byte cleared in reset", byte_data, 0);
    rst_n = 1'b1; tick(8);
    s0 = n_strobe; dc_sel = 1'b0; send_word(8, 9'h00F);
    expect_one("R9 partial discarded", s0, 8'h0F, 1'b0);
    cs_n = 1'b1; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_4w_r2();
    t_dc_late_r3();
    t_3w_r4_r5();
    t_idle_r6();
    t_abort_r7();
    t_b2b_r8();
    t_hold_r10();
    t_reset_mid_r9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule